// File: doc/BRIEF.md
# Bus Cycle Start Sequencer

This block sits at the front of a processor's external bus master. The core hands it one operand transfer at a time. Each transfer carries a byte address, a byte count, a three-bit address-space code, a direction flag and a cache-inhibit flag. The sequencer breaks the transfer into bus cycles that each fit inside one aligned word of a fixed-width port. For every cycle it first pulses an early cycle-start strobe, with all cycle attributes already driven. It then either commits the cycle by raising address strobe or drops it when an internal abort arrives.

The cycle-start strobe comes out before the cycle is committed. Outside logic may use it to begin its own timing, and uses address strobe to confirm that the cycle is real. An abort can come from three sources: an on-chip cache hit, a miss in the translation cache, or a protection fault. It is sampled at the clock edge that closes the start clock. An aborted cycle never shows address strobe and ends the whole operand. A committed cycle holds address strobe until the synchronous termination input is seen high at a rising edge. If bytes remain, the next cycle's start strobe appears in the very next clock.

A separate operand-start strobe marks only the first bus cycle of each operand, whether that operand is an instruction fetch or a data access.

Top module: `bus_cycle_starter`

## Requirements
- R1: After reset, `req_ready` is 1 and `cyc_start`, `opnd_start` and `addr_strobe` are 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. In the following clock `cyc_start` is 1 for exactly one clock, with `bus_addr`, `bus_size`, `bus_space`, `bus_write` and `bus_inhibit` already valid.
- R3: `opnd_start` is 1 together with `cyc_start` on the first bus cycle of an operand only. It stays 0 on every later cycle of the same operand, and is 1 again on the first cycle of the next operand.
- R4: If any of `abort_hit`, `abort_miss` or `abort_fault` is 1 during a `cyc_start` clock, `addr_strobe` stays 0 for that cycle. The operand ends and `req_ready` is 1 in the next clock.
- R5: Without an abort, `addr_strobe` is 1 in the clock after `cyc_start`. It stays 1 for every clock until termination is seen.
- R6: When `bus_term` is 1 at a rising edge while `addr_strobe` is 1, `addr_strobe` is 0 in the next clock. That clock carries `cyc_start` for the next cycle if bytes remain, and otherwise `req_ready` is 1.
- R7: `bus_term` has no effect while `addr_strobe` is 0, either when idle or during a `cyc_start` clock.
- R8: With the 4-byte port, `req_size`/`bus_size` code 0 means 4 bytes and codes 1 to 3 mean that many bytes. A cycle moves min(4 − addr[1:0], remaining) bytes. The next cycle's address is the next 4-byte-aligned address. Its `bus_size` is the remaining byte count modulo 4.
- R9: `bus_space`, `bus_write` and `bus_inhibit` keep the values of the accepted request for every cycle of that operand.
- R10: `req_ready` is 0 from acceptance until the operand ends. A request offered meanwhile is neither started nor allowed to change `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers an operand transfer |
| req_ready | output | 1 | Sequencer is idle and takes a request |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Byte count, 0 meaning a full port word |
| req_space | input | 3 | Address-space code |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_inhibit | input | 1 | Cache-inhibit flag for the access |
| abort_hit | input | 1 | On-chip cache supplied the operand |
| abort_miss | input | 1 | Translation cache missed |
| abort_fault | input | 1 | Translation reported a protection fault |
| bus_term | input | 1 | Synchronous cycle termination |
| cyc_start | output | 1 | Early cycle-start strobe, one clock |
| opnd_start | output | 1 | First cycle of an operand, with cyc_start |
| addr_strobe | output | 1 | Committed-cycle address strobe |
| bus_addr | output | 32 | Address of the current cycle |
| bus_size | output | 2 | Bytes still to move, modulo port width |
| bus_space | output | 3 | Address-space code of the current cycle |
| bus_write | output | 1 | Direction of the current cycle |
| bus_inhibit | output | 1 | Cache-inhibit output of the current cycle |

## Verification
The assertions assume that the abort inputs and `bus_term` are synchronous to `clk` and settle before each rising edge. They also assume that an abort is meaningful only in a start clock. The stimulus changes every input on the falling edge, raises an abort only in the start clock of the cycle it targets, and pulses termination for a single clock. Termination is also held high on purpose while idle and during a start clock, to show that it is ignored there.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int SPACE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_ACTIVE = 2'd2
  } bcs_state_e;

  typedef struct packed {
    logic [SPACE_W-1:0] space;
    logic               write;
    logic               inhibit;
  } bcs_attr_t;

endpackage

// File: rtl/bcs_split_unit.sv
module bcs_split_unit #(
  parameter int ADDR_W     = 32,
  parameter int PORT_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ADDR_W-1:0]             load_addr,
  input  logic [$clog2(PORT_BYTES)-1:0] load_size,
  input  logic                          advance,
  output logic [ADDR_W-1:0]             cur_addr,
  output logic [$clog2(PORT_BYTES)-1:0] size_field,
  output logic                          last_cycle
);

  localparam int OFF_W = $clog2(PORT_BYTES);
  localparam int CNT_W = OFF_W + 1;
  localparam int HI_W  = ADDR_W - OFF_W;

  // size code 0 stands for a full port word
  function automatic logic [CNT_W-1:0] decode_size(input logic [OFF_W-1:0] code);
    return (code == '0) ? CNT_W'(PORT_BYTES) : {1'b0, code};
  endfunction

  // bytes between an offset and the end of its port word
  function automatic logic [CNT_W-1:0] room_to_edge(input logic [OFF_W-1:0] off);
    return CNT_W'(PORT_BYTES) - {1'b0, off};
  endfunction

  function automatic logic [ADDR_W-1:0] next_boundary(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W] + HI_W'(1), {OFF_W{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  chunk;

  assign room       = room_to_edge(addr_q[OFF_W-1:0]);
  assign chunk      = (rem_q < room) ? rem_q : room;
  assign last_cycle = (rem_q <= room);
  assign cur_addr   = addr_q;
  assign size_field = rem_q[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= CNT_W'(PORT_BYTES);
    end else if (load) begin
      addr_q <= load_addr;
      rem_q  <= decode_size(load_size);
    end else if (advance) begin
      addr_q <= next_boundary(addr_q);
      rem_q  <= rem_q - chunk;
    end
  end

  // R8: a follow-on cycle always begins on a port-word boundary
  a_r8_aligned_follow: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cur_addr[OFF_W-1:0] == '0));

  // R8: the remaining count never runs dry while a cycle is pending
  a_r8_rem_positive: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q != '0);

endmodule

// File: rtl/bcs_strobe_fsm.sv
module bcs_strobe_fsm
  import bcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic abort_any,
  input  logic bus_term,
  input  logic last_cycle,
  output logic req_ready,
  output logic accept,
  output logic advance,
  output logic cyc_start,
  output logic opnd_start,
  output logic addr_strobe
);

  bcs_state_e state_q, state_d;
  logic       first_q;
  logic       term_seen;

  assign req_ready   = (state_q == ST_IDLE);
  assign cyc_start   = (state_q == ST_START);
  assign addr_strobe = (state_q == ST_ACTIVE);
  assign accept      = req_ready & req_valid;
  assign term_seen   = addr_strobe & bus_term;
  assign advance     = term_seen & ~last_cycle;
  assign opnd_start  = cyc_start & first_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_START;
      ST_START:  state_d = abort_any ? ST_IDLE : ST_ACTIVE;
      ST_ACTIVE: if (bus_term) state_d = last_cycle ? ST_IDLE : ST_START;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)       first_q <= 1'b1;
      else if (advance) first_q <= 1'b0;
    end
  end

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  a_r3_split_no_opnd: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && $past(addr_strobe)) |-> !opnd_start);

  a_r4_abort_blocks_as: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && abort_any) |=> (!addr_strobe && req_ready));

  a_r5_as_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !abort_any) |=> addr_strobe);

  a_r6_term_negates: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && bus_term) |=> !addr_strobe);

  a_r7_term_ignored_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && bus_term && !abort_any) |=> addr_strobe);

endmodule

// File: rtl/bus_cycle_starter.sv
module bus_cycle_starter
  import bcs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(PORT_BYTES)-1:0] req_size,
  input  logic [SPACE_W-1:0]            req_space,
  input  logic                          req_write,
  input  logic                          req_inhibit,
  input  logic                          abort_hit,
  input  logic                          abort_miss,
  input  logic                          abort_fault,
  input  logic                          bus_term,
  output logic                          cyc_start,
  output logic                          opnd_start,
  output logic                          addr_strobe,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic [$clog2(PORT_BYTES)-1:0] bus_size,
  output logic [SPACE_W-1:0]            bus_space,
  output logic                          bus_write,
  output logic                          bus_inhibit
);

  logic      accept;
  logic      advance;
  logic      last_cycle;
  logic      abort_any;
  bcs_attr_t attr_q;

  assign abort_any = abort_hit | abort_miss | abort_fault;

  bcs_strobe_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .abort_any   (abort_any),
    .bus_term    (bus_term),
    .last_cycle  (last_cycle),
    .req_ready   (req_ready),
    .accept      (accept),
    .advance     (advance),
    .cyc_start   (cyc_start),
    .opnd_start  (opnd_start),
    .addr_strobe (addr_strobe)
  );

  bcs_split_unit #(
    .ADDR_W     (ADDR_W),
    .PORT_BYTES (PORT_BYTES)
  ) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_addr  (req_addr),
    .load_size  (req_size),
    .advance    (advance),
    .cur_addr   (bus_addr),
    .size_field (bus_size),
    .last_cycle (last_cycle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= '0;
    else if (accept) attr_q <= '{space: req_space, write: req_write, inhibit: req_inhibit};
  end

  assign bus_space   = attr_q.space;
  assign bus_write   = attr_q.write;
  assign bus_inhibit = attr_q.inhibit;

  a_r9_attr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !opnd_start) |-> $stable({bus_space, bus_write, bus_inhibit}));

  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !cyc_start) |-> $stable(bus_addr));

endmodule

// File: tb/bus_cycle_starter_tb.sv
`timescale 1ns/1ps
module bus_cycle_starter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic        req_inhibit = 1'b0;
  logic        abort_hit = 1'b0;
  logic        abort_miss = 1'b0;
  logic        abort_fault = 1'b0;
  logic        bus_term = 1'b0;
  logic        cyc_start, opnd_start, addr_strobe;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [2:0]  bus_space;
  logic        bus_write, bus_inhibit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_starter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_space(req_space),
    .req_write(req_write), .req_inhibit(req_inhibit),
    .abort_hit(abort_hit), .abort_miss(abort_miss), .abort_fault(abort_fault),
    .bus_term(bus_term), .cyc_start(cyc_start), .opnd_start(opnd_start),
    .addr_strobe(addr_strobe), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_space(bus_space), .bus_write(bus_write), .bus_inhibit(bus_inhibit)
  );

  // {offset[1:0], size[1:0], space[2:0], write, inhibit, waits[1:0]}
  localparam logic [10:0] VEC [0:7] = '{
    {2'd0, 2'd0, 3'd1, 1'b0, 1'b0, 2'd0},
    {2'd1, 2'd0, 3'd2, 1'b1, 1'b0, 2'd1},
    {2'd2, 2'd2, 3'd5, 1'b0, 1'b1, 2'd0},
    {2'd3, 2'd2, 3'd6, 1'b1, 1'b1, 2'd2},
    {2'd3, 2'd1, 3'd7, 1'b0, 1'b0, 2'd0},
    {2'd2, 2'd0, 3'd4, 1'b1, 1'b0, 2'd3},
    {2'd1, 2'd3, 3'd3, 1'b0, 1'b1, 2'd1},
    {2'd0, 2'd3, 3'd0, 1'b1, 1'b1, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // abort_kind: 0 none, 1 cache hit, 2 translation miss, 3 fault
  task automatic run_op(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] sp,
                        input logic wr, input logic inh, input int waits,
                        input int abort_kind, input int abort_at);
    int rem;
    int chunk;
    int cyc;
    logic [31:0] ea;
    @(negedge clk);
    chk("R10 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    req_space = sp; req_write = wr; req_inhibit = inh;
    @(negedge clk);
    req_valid = 1'b0;
    rem = (sz == 2'd0) ? 4 : int'(sz);
    ea  = a;
    cyc = 0;
    forever begin
      chk("R2 cyc_start", cyc_start, 1);
      chk("R3 opnd_start", opnd_start, (cyc == 0) ? 1 : 0);
      chk("R8 address", bus_addr, ea);
      chk("R8 size field", bus_size, rem % 4);
      chk("R9 space", bus_space, sp);
      chk("R9 write", bus_write, wr);
      chk("R9 inhibit", bus_inhibit, inh);
      chk("R5 no strobe in start clock", addr_strobe, 0);
      chunk = 4 - int'(ea[1:0]);
      if (rem < chunk) chunk = rem;
      if (abort_kind != 0 && cyc == abort_at) begin
        abort_hit   = (abort_kind == 1);
        abort_miss  = (abort_kind == 2);
        abort_fault = (abort_kind == 3);
        @(negedge clk);
        abort_hit = 1'b0; abort_miss = 1'b0; abort_fault = 1'b0;
        chk("R4 strobe stays low", addr_strobe, 0);
        chk("R4 ready after abort", req_ready, 1);
        chk("R4 no further start", cyc_start, 0);
        return;
      end
      @(negedge clk);
      chk("R5 strobe after start", addr_strobe, 1);
      chk("R2 start lasts one clock", cyc_start, 0);
      chk("R10 busy", req_ready, 0);
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk("R5 strobe held", addr_strobe, 1);
      end
      bus_term = 1'b1;
      @(negedge clk);
      bus_term = 1'b0;
      chk("R6 strobe dropped", addr_strobe, 0);
      rem = rem - chunk;
      ea  = {ea[31:2], 2'b00} + 32'd4;
      cyc++;
      if (rem == 0) begin
        chk("R6 no start after last", cyc_start, 0);
        chk("R6 ready after last", req_ready, 1);
        return;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 cyc_start", cyc_start, 0);
    chk("R1 opnd_start", opnd_start, 0);
    chk("R1 addr_strobe", addr_strobe, 0);

    for (int i = 0; i < 8; i++) begin
      run_op(32'h1000_0000 + 32'(i) * 32'h40 + {30'd0, VEC[i][10:9]}, VEC[i][8:7],
             VEC[i][6:4], VEC[i][3], VEC[i][2], int'(VEC[i][1:0]), 0, 0);
    end

    // R8: every byte offset against every size
    for (int off = 0; off < 4; off++) begin
      for (int s = 0; s < 4; s++) begin
        run_op(32'h0000_8000 + 32'(off), 2'(s), 3'(s + off), off[0], s[0], 0, 0, 0);
      end
    end

    // R4: each abort source on a first cycle, then on a follow-on cycle
    run_op(32'h0000_4000, 2'd0, 3'd1, 1'b0, 1'b0, 0, 1, 0);
    run_op(32'h0000_4001, 2'd0, 3'd2, 1'b1, 1'b0, 0, 2, 0);
    run_op(32'h0000_4003, 2'd0, 3'd5, 1'b0, 1'b1, 0, 3, 1);
    // R3: next operand after an abort gets its own operand-start strobe
    run_op(32'h0000_4102, 2'd0, 3'd6, 1'b1, 1'b0, 1, 0, 0);

    // R7: termination while idle does nothing
    @(negedge clk);
    bus_term = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 idle term start", cyc_start, 0);
      chk("R7 idle term strobe", addr_strobe, 0);
      chk("R7 idle term ready", req_ready, 1);
    end
    bus_term = 1'b0;

    // R7 and R10: termination during start clock, request offered while busy
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2000_0000; req_size = 2'd0;
    req_space = 3'd2; req_write = 1'b0; req_inhibit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    bus_term  = 1'b1;
    chk("R7 start present", cyc_start, 1);
    @(negedge clk);
    chk("R7 term at start ignored", addr_strobe, 1);
    bus_term  = 1'b0;
    req_valid = 1'b1; req_addr = 32'h3000_0004; req_size = 2'd1; req_space = 3'd7;
    @(negedge clk);
    chk("R10 ready low while busy", req_ready, 0);
    chk("R10 address kept", bus_addr, 32'h2000_0000);
    chk("R10 space kept", bus_space, 3'd2);
    chk("R10 no new start", cyc_start, 0);
    req_valid = 1'b0;
    bus_term  = 1'b1;
    @(negedge clk);
    bus_term = 1'b0;
    chk("R6 strobe dropped", addr_strobe, 0);
    chk("R10 busy request not started", cyc_start, 0);
    chk("R6 ready after single cycle", req_ready, 1);
    @(negedge clk);
    chk("R10 still idle", cyc_start, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule